// File: doc/BRIEF.md
# Twiddle ROM Address Generator for Mixed-Radix FFT Stages

This block sits beside the butterfly unit of a memory-based mixed-radix FFT engine. A stage controller issues one request per butterfly. Each request carries the radix of the current stage, its base family (powers of 2, 3 or 5), its level, a hold length, a flag for stages that belong to the coprime (prime-factor) part of the decomposition, a flag for decimation-in-time operation and a first-of-stage marker. For every butterfly operand the block returns a twiddle exponent. That exponent is already scaled to the full period of the ROM that serves the family. The block also returns the ROM select and a per-operand flag that marks a unity twiddle, so the multiplier for that operand can be bypassed.

Inside one coprime factor of size M = base^D, a stage at level L works on sub-transforms of size Ns = base^L. Such a stage has G = Ns / radix distinct group positions. The twiddle for operand j at position p is W_Ns^(j·p), which is address j·p·(M/Ns) in the family ROM. The block tracks p by itself. It counts the requests accepted since the last first-of-stage marker. In decimation-in-frequency order it holds each position for a block of consecutive butterflies, and in decimation-in-time order it steps the position on every butterfly.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. An input is taken on a clock edge where in_valid and in_ready are both high. The single output register stays stable while out_valid is high and out_ready is low. in_ready is high whenever that register is empty or is being drained in the same cycle.

Top module: `twd_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 until the first request is accepted.
- R2: A request accepted on a clock edge produces its result at out_valid on that same edge, so the latency is one cycle. While out_valid=1 and out_ready=0 all outputs hold their values. in_ready is 1 whenever the output register is empty or out_ready=1.
- R3: out_rom_sel equals the family code of the request: 0 for base 2 (radix 2 and radix 4), 1 for base 3 (radix 3), 2 for base 5 (radix 5).
- R4: Operand 0 always gets a trivial twiddle. So does every operand whose index j is not below the radix. A trivial operand has its out_trivial bit set to 1 and its address set to 0. The address of operand j occupies out_addr[j*ADDR_W +: ADDR_W].
- R5: Take a valid configuration: M = base^Dmax, where Dmax is 6, 3 and 2 for bases 2, 3 and 5 by default, Ns = base^level and p is the current group position. Then operand j < radix gets the address j·p·(M/Ns). Its trivial bit is 1 exactly when that address is 0.
- R6: With in_dit=0, let k be the number of requests accepted since the last request with in_first=1, where that first request has k=0. Then the group position is p = floor(k / hold) mod G, with G = Ns / radix. A hold value of 0 acts as 1.
- R7: With in_dit=1 the group position is p = k mod G, and in_hold has no effect.
- R8: At the last stage of a factor (level = 1 for radix 2, 3 and 5, level = 2 for radix 4) G is 1, so every operand is trivial.
- R9: A request with in_coprime=1 produces all-trivial operands with all addresses 0.
- R10: An unsupported configuration produces all-trivial operands. This covers a family code of 3, a radix that does not belong to its family, and a level below the radix's digit count or above Dmax.
- R11: out_at_input equals the in_dit of the request, and tells the datapath whether the twiddle multiplies the butterfly input (1) or its output (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_fam | input | 2 | Base family code (0: base 2, 1: base 3, 2: base 5) |
| in_radix | input | 3 | Stage radix (2, 3, 4 or 5) |
| in_level | input | LVL_W | Level: sub-transform size is base^level |
| in_hold | input | HOLD_W | Number of consecutive butterflies that share one position (DIF order) |
| in_coprime | input | 1 | Stage belongs to the coprime part, so no twiddles |
| in_dit | input | 1 | Decimation-in-time ordering and input-side twiddles |
| in_first | input | 1 | First butterfly of a stage, restarts the position count |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_rom_sel | output | 2 | ROM select (family code) |
| out_addr | output | NUM_OPS*ADDR_W | Renormalised ROM address per operand |
| out_trivial | output | NUM_OPS | Unity twiddle flag per operand |
| out_at_input | output | 1 | Twiddle applies at the butterfly input |

## Verification
Each result is due one cycle after its request is accepted. It is held for as many cycles as out_ready stays low. The bench sweeps every valid family, radix and level in both orderings with hold lengths 1 to 3, while a pseudo-random out_ready adds back-pressure. When a request is accepted, the bench pushes the arithmetic expectation for it into a queue. On falling edges where out_valid and out_ready are both high, it pops one expectation and compares it, so the check does not depend on how long a stall lasted. A separate falling-edge check confirms that a stalled result stays unchanged until it is taken.

// File: rtl/twd_pkg.sv
package twd_pkg;

  typedef enum logic [1:0] {
    FAM_B2 = 2'd0,
    FAM_B3 = 2'd1,
    FAM_B5 = 2'd2,
    FAM_NONE = 2'd3
  } twd_fam_e;

  // Small integer power; exponents beyond 15 are not used by this block.
  function automatic logic [31:0] ipow(input logic [31:0] b, input logic [31:0] e);
    logic [31:0] res;
    res = 32'd1;
    for (int i = 0; i < 16; i++) begin
      if (32'(i) < e) res = res * b;
    end
    return res;
  endfunction

  function automatic int max_period(input int d2, input int d3, input int d5);
    int m2, m3, m5, m;
    m2 = int'(ipow(32'd2, 32'(d2)));
    m3 = int'(ipow(32'd3, 32'(d3)));
    m5 = int'(ipow(32'd5, 32'(d5)));
    m = m2;
    if (m3 > m) m = m3;
    if (m5 > m) m = m5;
    return m;
  endfunction

endpackage

// File: rtl/twd_stage_geom.sv
// Derives the group count and the ROM renormalisation step of a stage.
module twd_stage_geom
  import twd_pkg::*;
#(
  parameter int P2_DIG = 6,
  parameter int P3_DIG = 3,
  parameter int P5_DIG = 2,
  parameter int LVL_W  = 3,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic [1:0]        fam,
  input  logic [2:0]        radix,
  input  logic [LVL_W-1:0]  level,
  output logic [CNT_W-1:0]  grp_len,
  output logic [ADDR_W-1:0] renorm,
  output logic              cfg_ok
);

  logic [31:0] base_v;
  logic [31:0] maxd_v;
  logic [31:0] rdig_v;
  logic [31:0] lvl_v;
  logic        radix_match;

  always_comb begin
    lvl_v = 32'(level);
    case (twd_fam_e'(fam))
      FAM_B2: begin
        base_v      = 32'd2;
        maxd_v      = 32'(P2_DIG);
        radix_match = (radix == 3'd2) || (radix == 3'd4);
      end
      FAM_B3: begin
        base_v      = 32'd3;
        maxd_v      = 32'(P3_DIG);
        radix_match = (radix == 3'd3);
      end
      FAM_B5: begin
        base_v      = 32'd5;
        maxd_v      = 32'(P5_DIG);
        radix_match = (radix == 3'd5);
      end
      default: begin
        base_v      = 32'd1;
        maxd_v      = 32'd0;
        radix_match = 1'b0;
      end
    endcase
    // A radix-4 stage consumes two binary digits of the sub-transform size.
    rdig_v = (radix == 3'd4) ? 32'd2 : 32'd1;
    cfg_ok = radix_match && (lvl_v >= rdig_v) && (lvl_v <= maxd_v);
    if (cfg_ok) begin
      grp_len = CNT_W'(ipow(base_v, lvl_v - rdig_v));
      renorm  = ADDR_W'(ipow(base_v, maxd_v - lvl_v));
    end else begin
      grp_len = CNT_W'(1);
      renorm  = '0;
    end
  end

endmodule

// File: rtl/twd_pos_track.sv
// Tracks the group position of the current butterfly inside a stage.
module twd_pos_track #(
  parameter int CNT_W  = 6,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              first,
  input  logic              dit,
  input  logic [HOLD_W-1:0] hold,
  input  logic [CNT_W-1:0]  grp_len,
  output logic [CNT_W-1:0]  pos
);

  logic [CNT_W-1:0]  pos_q;
  logic [HOLD_W-1:0] hcnt_q;
  logic [HOLD_W-1:0] cur_h;
  logic [HOLD_W-1:0] hold_eff;
  logic [CNT_W-1:0]  pos_adv;
  logic [CNT_W-1:0]  pos_nxt;
  logic [HOLD_W-1:0] hcnt_nxt;
  logic              pos_wrap;
  logic              hold_done;

  assign pos      = first ? '0 : pos_q;
  assign cur_h    = first ? '0 : hcnt_q;
  assign hold_eff = (hold == '0) ? HOLD_W'(1) : hold;

  assign pos_wrap  = ({1'b0, pos} + (CNT_W+1)'(1)) >= {1'b0, grp_len};
  assign pos_adv   = pos_wrap ? '0 : pos + CNT_W'(1);
  assign hold_done = ({1'b0, cur_h} + (HOLD_W+1)'(1)) >= {1'b0, hold_eff};

  always_comb begin
    if (dit) begin
      // Group-major order: position advances on every butterfly.
      pos_nxt  = pos_adv;
      hcnt_nxt = '0;
    end else if (hold_done) begin
      pos_nxt  = pos_adv;
      hcnt_nxt = '0;
    end else begin
      pos_nxt  = pos;
      hcnt_nxt = cur_h + HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hcnt_q <= '0;
    end else if (step) begin
      pos_q  <= pos_nxt;
      hcnt_q <= hcnt_nxt;
    end
  end

endmodule

// File: rtl/twd_op_addr.sv
// Address and unity flag for one butterfly operand.
module twd_op_addr #(
  parameter int OP     = 0,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic [2:0]        radix,
  input  logic [CNT_W-1:0]  pos,
  input  logic [ADDR_W-1:0] renorm,
  input  logic              force_triv,
  output logic [ADDR_W-1:0] addr,
  output logic              triv
);

  localparam int PW = ADDR_W + CNT_W + 4;

  logic [PW-1:0] prod;
  logic          unused_op;

  // j*p < G*radix / radix * ... stays below the ROM period, so no wrap.
  assign prod      = PW'(OP) * PW'(pos) * PW'(renorm);
  assign unused_op = (32'(radix) <= 32'(OP));
  assign triv      = force_triv || unused_op || (prod == '0);
  assign addr      = triv ? '0 : prod[ADDR_W-1:0];

endmodule

// File: rtl/twd_addr_gen.sv
module twd_addr_gen
  import twd_pkg::*;
#(
  parameter int NUM_OPS = 5,
  parameter int P2_DIG  = 6,
  parameter int P3_DIG  = 3,
  parameter int P5_DIG  = 2,
  parameter int LVL_W   = 3,
  parameter int HOLD_W  = 4,
  localparam int ADDR_W = $clog2(max_period(P2_DIG, P3_DIG, P5_DIG)),
  localparam int CNT_W  = ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_fam,
  input  logic [2:0]                in_radix,
  input  logic [LVL_W-1:0]          in_level,
  input  logic [HOLD_W-1:0]         in_hold,
  input  logic                      in_coprime,
  input  logic                      in_dit,
  input  logic                      in_first,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [1:0]                out_rom_sel,
  output logic [NUM_OPS*ADDR_W-1:0] out_addr,
  output logic [NUM_OPS-1:0]        out_trivial,
  output logic                      out_at_input
);

  logic                      accept;
  logic [CNT_W-1:0]          grp_len;
  logic [ADDR_W-1:0]         renorm;
  logic                      cfg_ok;
  logic [CNT_W-1:0]          pos;
  logic                      force_triv;
  logic [NUM_OPS*ADDR_W-1:0] addr_w;
  logic [NUM_OPS-1:0]        triv_w;

  assign in_ready   = !out_valid || out_ready;
  assign accept     = in_valid && in_ready;
  assign force_triv = in_coprime || !cfg_ok;

  twd_stage_geom #(
    .P2_DIG(P2_DIG), .P3_DIG(P3_DIG), .P5_DIG(P5_DIG),
    .LVL_W(LVL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_geom (
    .fam(in_fam), .radix(in_radix), .level(in_level),
    .grp_len(grp_len), .renorm(renorm), .cfg_ok(cfg_ok)
  );

  twd_pos_track #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(accept), .first(in_first),
    .dit(in_dit), .hold(in_hold), .grp_len(grp_len), .pos(pos)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    twd_op_addr #(.OP(g), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_op (
      .radix(in_radix), .pos(pos), .renorm(renorm), .force_triv(force_triv),
      .addr(addr_w[g*ADDR_W +: ADDR_W]), .triv(triv_w[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_rom_sel  <= '0;
      out_addr     <= '0;
      out_trivial  <= '0;
      out_at_input <= 1'b0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_rom_sel  <= in_fam;
      out_addr     <= addr_w;
      out_trivial  <= triv_w;
      out_at_input <= in_dit;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/twd_addr_gen_chk.sv
module twd_addr_gen_chk #(
  parameter int NUM_OPS = 5,
  parameter int ADDR_W  = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [1:0]                in_fam,
  input logic                      in_coprime,
  input logic                      in_dit,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [1:0]                out_rom_sel,
  input logic [NUM_OPS*ADDR_W-1:0] out_addr,
  input logic [NUM_OPS-1:0]        out_trivial,
  input logic                      out_at_input
);

  a_r2_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_trivial) && $stable(out_rom_sel) && $stable(out_at_input)));

  a_r3_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_rom_sel == $past(in_fam)));

  a_r11_side_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_at_input == $past(in_dit)));

  a_r9_coprime_trivial: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_coprime) |=> ((&out_trivial) && (out_addr == '0)));

  a_r4_op0_trivial: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_trivial[0] && (out_addr[ADDR_W-1:0] == '0)));

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_zero
    a_r5_trivial_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_trivial[g] == (out_addr[g*ADDR_W +: ADDR_W] == '0)));
  end

endmodule

bind twd_addr_gen twd_addr_gen_chk #(.NUM_OPS(NUM_OPS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/twd_addr_gen_bench.sv
`timescale 1ns/1ps
module twd_addr_gen_bench;

  localparam int NOP = 5;
  localparam int AW  = 6;

  typedef struct packed {
    logic [1:0]      sel;
    logic            ati;
    logic [NOP-1:0]  tr;
    logic [NOP*AW-1:0] ad;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [1:0]        in_fam;
  logic [2:0]        in_radix;
  logic [2:0]        in_level;
  logic [3:0]        in_hold;
  logic              in_coprime;
  logic              in_dit;
  logic              in_first;
  logic              out_valid;
  logic              out_ready;
  logic [1:0]        out_rom_sel;
  logic [NOP*AW-1:0] out_addr;
  logic [NOP-1:0]    out_trivial;
  logic              out_at_input;

  twd_addr_gen u_twd_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fam(in_fam), .in_radix(in_radix), .in_level(in_level), .in_hold(in_hold),
    .in_coprime(in_coprime), .in_dit(in_dit), .in_first(in_first),
    .out_valid(out_valid), .out_ready(out_ready), .out_rom_sel(out_rom_sel),
    .out_addr(out_addr), .out_trivial(out_trivial), .out_at_input(out_at_input)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  exp_t  q_exp[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  // Reference: arithmetic from the requirement text.
  function automatic exp_t model(input int f, input int r, input int lv, input int h,
                                 input bit cop, input bit dit, input int k);
    exp_t e;
    int b, md, rd, m, ns, g, rn, p, hh, a;
    bit ok;
    b = 1; md = 0; ok = 0;
    if (f == 0) begin b = 2; md = 6; ok = (r == 2 || r == 4); end
    if (f == 1) begin b = 3; md = 3; ok = (r == 3); end
    if (f == 2) begin b = 5; md = 2; ok = (r == 5); end
    rd = (r == 4) ? 2 : 1;
    ok = ok && (lv >= rd) && (lv <= md);
    e.sel = 2'(f);
    e.ati = dit;
    e.tr  = '1;
    e.ad  = '0;
    if (ok && !cop) begin
      m = 1; for (int i = 0; i < md; i++) m = m * b;
      ns = 1; for (int i = 0; i < lv; i++) ns = ns * b;
      g  = ns / r;
      rn = m / ns;
      hh = (h == 0) ? 1 : h;
      p  = dit ? (k % g) : ((k / hh) % g);
      for (int j = 0; j < NOP; j++) begin
        a = (j < r) ? j * p * rn : 0;
        e.ad[j*AW +: AW] = AW'(a);
        e.tr[j] = (a == 0);
      end
    end
    return e;
  endfunction

  task automatic send(input int f, input int r, input int lv, input int h,
                      input bit cop, input bit dit, input bit first,
                      input exp_t e, input string tag);
    bit acc;
    @(negedge clk);
    in_fam = 2'(f); in_radix = 3'(r); in_level = 3'(lv); in_hold = 4'(h);
    in_coprime = cop; in_dit = dit; in_first = first; in_valid = 1'b1;
    acc = 0;
    while (!acc) begin
      #1;
      if (in_ready) begin
        acc = 1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(posedge clk);
        #1 in_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic run_cfg(input int f, input int r, input int lv, input int h,
                         input bit cop, input bit dit, input int n, input string tag);
    for (int k = 0; k < n; k++)
      send(f, r, lv, h, cop, dit, (k == 0), model(f, r, lv, h, cop, dit, k), tag);
  endtask

  // Back-pressure pattern.
  logic [7:0] lfsr = 8'hA5;
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[2];
    end
  end

  // Output compare at transfer.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q_exp.size() == 0) begin
        chk(0, "R2", "output without request", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(out_rom_sel == e.sel, "R3", "rom select", out_rom_sel, e.sel);
        chk(out_at_input == e.ati, "R11", "twiddle side", out_at_input, e.ati);
        chk(out_trivial == e.tr, t, "trivial flags", out_trivial, e.tr);
        chk(out_addr == e.ad, t, "addresses", out_addr, e.ad);
      end
    end
  end

  // Stalled result must stay put (R2).
  bit stall_prev = 0;
  logic [NOP*AW+NOP+2:0] stall_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        chk(out_valid && ({out_addr, out_trivial, out_rom_sel, out_at_input} == stall_val),
            "R2", "stalled output changed",
            {out_valid, out_addr, out_trivial, out_rom_sel, out_at_input},
            {1'b1, stall_val});
      stall_prev = out_valid && !out_ready;
      stall_val  = {out_addr, out_trivial, out_rom_sel, out_at_input};
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int md, rd, base, ns, g;
    string tg;
    rst_n = 1'b0; in_valid = 1'b0; in_fam = '0; in_radix = 3'd2; in_level = '0;
    in_hold = '0; in_coprime = 0; in_dit = 0; in_first = 0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R2", "in_ready when empty", in_ready, 1);

    // Sweep every valid (family, radix, level), both orders, holds 1..3 (R5 R6 R7 R8).
    for (int f = 0; f < 3; f++) begin
      for (int r = 2; r <= 5; r++) begin
        base = (f == 0) ? 2 : (f == 1) ? 3 : 5;
        md   = (f == 0) ? 6 : (f == 1) ? 3 : 2;
        if (!((f == 0 && (r == 2 || r == 4)) || (f == 1 && r == 3) || (f == 2 && r == 5)))
          continue;
        rd = (r == 4) ? 2 : 1;
        for (int lv = rd; lv <= md; lv++) begin
          ns = 1; for (int i = 0; i < lv; i++) ns = ns * base;
          g = ns / r;
          for (int d = 0; d < 2; d++) begin
            for (int h = 1; h <= 3; h++) begin
              if (lv == rd) tg = "R8 R4";
              else if (d == 1) tg = "R7 R5";
              else tg = "R6 R5";
              run_cfg(f, r, lv, h, 0, d[0], 2 * g * h + 1, tg);
            end
          end
        end
      end
    end

    // Hold of zero behaves like one (R6).
    run_cfg(0, 2, 4, 0, 0, 0, 20, "R6 hold0");
    // Coprime stages: no twiddles (R9).
    run_cfg(0, 4, 6, 1, 1, 0, 12, "R9");
    run_cfg(1, 3, 3, 2, 1, 1, 10, "R9");
    // Unsupported configurations (R10).
    run_cfg(3, 2, 2, 1, 0, 0, 4, "R10 fam3");
    run_cfg(1, 5, 2, 1, 0, 0, 4, "R10 radix");
    run_cfg(0, 4, 1, 1, 0, 0, 4, "R10 low level");
    run_cfg(2, 5, 3, 1, 0, 1, 4, "R10 high level");
    // Restart mid-stage after a configuration change (R6).
    run_cfg(2, 5, 2, 2, 0, 0, 7, "R6 restart");
    run_cfg(2, 5, 2, 2, 0, 0, 12, "R6 restart");

    for (int w = 0; w < 2000 && q_exp.size() != 0; w++) @(negedge clk);
    chk(q_exp.size() == 0, "R2", "results outstanding", q_exp.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule